// File: doc/BRIEF.md
# Auxiliary-Channel Request Engine

This block lets a host processor build, launch and collect one display auxiliary-channel transaction through a small byte-wide register window. The host loads a 20-bit target address and a 4-bit command, sets a length code, and pushes any outgoing payload bytes into a 16-entry transmit FIFO. It then sets a send bit. The engine latches the request and hands it to the link side through valid/ready handshakes. It waits for a reply class and byte count, gathers any returned bytes into a 16-entry receive FIFO, and finally latches a status byte. The host then pops the returned bytes one register read at a time.

The sequencer is a five-state machine. IDLE goes to REQUEST on an accepted send. REQUEST goes to WRITE_DATA when the link takes the request and the command writes a non-empty payload; otherwise it goes to WAIT_REPLY. WRITE_DATA goes to WAIT_REPLY once the last payload byte is taken. WAIT_REPLY goes to READ_DATA on a reply that carries bytes for a read command; otherwise it returns to IDLE. READ_DATA returns to IDLE after the last returned byte. Any busy state returns to IDLE when the cycle budget runs out or when the host writes the clear code to the configuration register.

Top module: `aux_req_engine`

## Requirements
- R1: After reset every register reads 0x00, the send bit reads 0 and no link-side valid is asserted.
- R2: Offset 0x7D holds address bits 7:0 and offset 0x7E holds bits 15:8. Offset 0x7F holds address bits 19:16 in its low nibble and the command in its high nibble. All three read back as written. The latched command and address appear on `lnk_cmd` and `lnk_addr` while the request is offered.
- R3: Offset 0x80 bits 3:0 hold the byte count minus one, so the request carries code+1 bytes (1 to 16) on `lnk_len`. When bit 7 is set, `lnk_len` is 0 whatever bits 3:0 hold, and no payload or returned byte is moved.
- R4: Each write to offset 0x81 pushes one byte into the transmit FIFO. A push into a full FIFO (16 bytes) is dropped. For a write command (command bit 0 = 0), the bytes leave in push order on `lnk_wr_data`, one per cycle in which `lnk_wr_valid` and `lnk_wr_ready` are both high.
- R5: Writing bit 0 of offset 0x83 launches the request. That bit reads 1 from the next cycle until the request ends, then reads 0. A send written while a request is in flight has no effect.
- R6: On completion, offset 0x84 holds the reply class in bits 7:5, with 1=NACK, 2=DEFER, 3=ACK, 4=invalid, 5=I2C NACK, 6=I2C DEFER and 7=timeout. Bits 4:0 hold the reply count, saturated to 16.
- R7: For a read command (command bit 0 = 1) with a payload, the engine stores as many returned bytes as the saturated reply count. Reads of offset 0x82 pop them in arrival order.
- R8: A read of offset 0x82 while the receive FIFO is empty returns 0x00 and leaves the FIFO unchanged.
- R9: If a request is still in flight `TIMEOUT_CYC` cycles after its launch edge, it ends. The status becomes 0xE0 (class 7, count 0) and the send bit clears.
- R10: Writing 0xFF to offset 0x76 returns every register, both FIFOs and the sequencer to the reset state, including a request in flight. It wins over a reply that arrives in the same cycle. Any other value written there has no effect.
- R11: Offsets not listed above read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at offset 0x82) |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| lnk_req_valid | output | 1 | Request offered to the link |
| lnk_req_ready | input | 1 | Link accepts the request |
| lnk_cmd | output | 4 | Latched command |
| lnk_addr | output | 20 | Latched target address |
| lnk_len | output | 5 | Payload byte count, 0 to 16 |
| lnk_wr_valid | output | 1 | Payload byte offered |
| lnk_wr_ready | input | 1 | Link takes the payload byte |
| lnk_wr_data | output | 8 | Payload byte |
| lnk_rsp_valid | input | 1 | Reply class and count valid |
| lnk_rsp_class | input | 3 | Reply class |
| lnk_rsp_count | input | 5 | Reply byte count |
| lnk_rd_valid | input | 1 | Returned byte valid |
| lnk_rd_data | input | 8 | Returned byte |

## Verification
Two events can fall in the same clock edge: a host clear written to offset 0x76 and a link reply finishing a request. The bench provokes this by raising `lnk_rsp_valid` and the clear write in the same cycle during WAIT_REPLY. It then expects the send bit and status to read 0, the receive FIFO to pop 0x00 and no request to restart, so the clear must have won. A send written during WAIT_REPLY is a second same-cycle case. It is judged by the absence of any new request once the first one has finished.

// File: rtl/aux_eng_pkg.sv
package aux_eng_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned ADDR_W      = 20;
    localparam int unsigned CMD_W       = 4;
    localparam int unsigned CNT_W       = 5;
    localparam int unsigned LCODE_W     = 4;
    localparam int unsigned CLASS_W     = 3;
    localparam int unsigned MAX_PAYLOAD = 16;

    localparam logic [7:0] OFS_CFG   = 8'h76;
    localparam logic [7:0] OFS_ADR0  = 8'h7D;
    localparam logic [7:0] OFS_ADR1  = 8'h7E;
    localparam logic [7:0] OFS_ADR2  = 8'h7F;
    localparam logic [7:0] OFS_LEN   = 8'h80;
    localparam logic [7:0] OFS_WDAT  = 8'h81;
    localparam logic [7:0] OFS_RDAT  = 8'h82;
    localparam logic [7:0] OFS_CTRL  = 8'h83;
    localparam logic [7:0] OFS_STAT  = 8'h84;
    localparam logic [7:0] CFG_CLEAR = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WDAT,
        ST_WAIT,
        ST_RDAT
    } seq_state_t;

    typedef enum logic [CLASS_W-1:0] {
        RC_NONE      = 3'd0,
        RC_NACK      = 3'd1,
        RC_DEFER     = 3'd2,
        RC_ACK       = 3'd3,
        RC_INVALID   = 3'd4,
        RC_I2C_NACK  = 3'd5,
        RC_I2C_DEFER = 3'd6,
        RC_TIMEOUT   = 3'd7
    } reply_class_t;

    typedef struct packed {
        logic [CMD_W-1:0]   cmd;
        logic [ADDR_W-1:0]  addr;
        logic               nopay;
        logic [LCODE_W-1:0] len_code;
    } req_desc_t;

endpackage

// File: rtl/aux_byte_fifo.sv
module aux_byte_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;

    logic do_push;
    logic do_pop;

    always_comb begin
        empty   = (fill == '0);
        full    = (fill == CNT_FULL);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = empty ? '0 : mem[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wr_ptr] <= push_data;
        end
    end

endmodule

// File: rtl/aux_host_regs.sv
module aux_host_regs
    import aux_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              seq_busy,
    input  logic [7:0]        seq_status,
    input  logic [BYTE_W-1:0] rx_head,
    output req_desc_t         desc,
    output logic              clr,
    output logic              send,
    output logic              tx_push,
    output logic [BYTE_W-1:0] tx_data,
    output logic              rx_pop
);
    logic [7:0] adr0_q;
    logic [7:0] adr1_q;
    logic [7:0] adr2_q;
    logic [7:0] len_q;

    always_comb begin
        clr     = reg_wr && (reg_addr == OFS_CFG) && (reg_wdata == CFG_CLEAR);
        send    = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];
        tx_push = reg_wr && (reg_addr == OFS_WDAT);
        tx_data = reg_wdata;
        rx_pop  = reg_rd && (reg_addr == OFS_RDAT);

        desc.addr     = {adr2_q[3:0], adr1_q, adr0_q};
        desc.cmd      = adr2_q[7:4];
        desc.nopay    = len_q[7];
        desc.len_code = len_q[LCODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adr0_q <= '0;
            adr1_q <= '0;
            adr2_q <= '0;
            len_q  <= '0;
        end else if (clr) begin
            adr0_q <= '0;
            adr1_q <= '0;
            adr2_q <= '0;
            len_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_ADR0: adr0_q <= reg_wdata;
                OFS_ADR1: adr1_q <= reg_wdata;
                OFS_ADR2: adr2_q <= reg_wdata;
                OFS_LEN:  len_q  <= {reg_wdata[7], 3'b000, reg_wdata[LCODE_W-1:0]};
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_ADR0: reg_rdata = adr0_q;
            OFS_ADR1: reg_rdata = adr1_q;
            OFS_ADR2: reg_rdata = adr2_q;
            OFS_LEN:  reg_rdata = len_q;
            OFS_RDAT: reg_rdata = rx_head;
            OFS_CTRL: reg_rdata = {7'b0, seq_busy};
            OFS_STAT: reg_rdata = seq_status;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/aux_link_seq.sv
module aux_link_seq
    import aux_eng_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               send,
    input  req_desc_t          desc,
    input  logic [BYTE_W-1:0]  tx_head,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [BYTE_W-1:0]  rx_data,
    output logic               busy,
    output logic [7:0]         status,
    output logic               lnk_req_valid,
    input  logic               lnk_req_ready,
    output logic [CMD_W-1:0]   lnk_cmd,
    output logic [ADDR_W-1:0]  lnk_addr,
    output logic [CNT_W-1:0]   lnk_len,
    output logic               lnk_wr_valid,
    input  logic               lnk_wr_ready,
    output logic [BYTE_W-1:0]  lnk_wr_data,
    input  logic               lnk_rsp_valid,
    input  logic [CLASS_W-1:0] lnk_rsp_class,
    input  logic [CNT_W-1:0]   lnk_rsp_count,
    input  logic               lnk_rd_valid,
    input  logic [BYTE_W-1:0]  lnk_rd_data
);
    localparam int unsigned TMO_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_PAYLOAD);

    seq_state_t state_q;
    seq_state_t state_d;

    logic [CMD_W-1:0]   cur_cmd;
    logic [ADDR_W-1:0]  cur_addr;
    logic [CNT_W-1:0]   cur_len;
    logic [CNT_W-1:0]   sent_cnt;
    logic [CNT_W-1:0]   rd_left;
    logic [CLASS_W-1:0] pend_class;
    logic [CNT_W-1:0]   pend_cnt;
    logic [TMO_W-1:0]   tmo_cnt;
    logic [7:0]         status_q;

    logic               start;
    logic               cur_read;
    logic [CNT_W-1:0]   rsp_cap;
    logic [CNT_W-1:0]   desc_len;
    logic               finish;
    logic [7:0]         fin_status;
    logic               tmo_fire;

    always_comb begin
        desc_len = desc.nopay ? '0 : CNT_W'(desc.len_code) + 1'b1;
        rsp_cap  = (lnk_rsp_count > CNT_MAX) ? CNT_MAX : lnk_rsp_count;
        cur_read = cur_cmd[0];
        start    = (state_q == ST_IDLE) && send;
    end

    // next-state logic
    always_comb begin
        state_d    = state_q;
        finish     = 1'b0;
        fin_status = status_q;
        unique case (state_q)
            ST_IDLE: begin
                if (send) state_d = ST_REQ;
            end
            ST_REQ: begin
                if (lnk_req_ready) begin
                    state_d = (!cur_read && cur_len != '0) ? ST_WDAT : ST_WAIT;
                end
            end
            ST_WDAT: begin
                if (lnk_wr_ready && (sent_cnt == cur_len - 1'b1)) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (lnk_rsp_valid) begin
                    if (cur_read && cur_len != '0 && rsp_cap != '0) begin
                        state_d = ST_RDAT;
                    end else begin
                        state_d    = ST_IDLE;
                        finish     = 1'b1;
                        fin_status = {lnk_rsp_class, rsp_cap};
                    end
                end
            end
            ST_RDAT: begin
                if (lnk_rd_valid && rd_left == 1) begin
                    state_d    = ST_IDLE;
                    finish     = 1'b1;
                    fin_status = {pend_class, pend_cnt};
                end
            end
            default: state_d = ST_IDLE;
        endcase
        tmo_fire = (state_q != ST_IDLE) && (tmo_cnt == TMO_LAST) && !finish;
        if (tmo_fire) state_d = ST_IDLE;
        if (clr) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request context, counters and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cmd    <= '0;
            cur_addr   <= '0;
            cur_len    <= '0;
            sent_cnt   <= '0;
            rd_left    <= '0;
            pend_class <= '0;
            pend_cnt   <= '0;
            tmo_cnt    <= '0;
            status_q   <= '0;
        end else if (clr) begin
            cur_cmd    <= '0;
            cur_addr   <= '0;
            cur_len    <= '0;
            sent_cnt   <= '0;
            rd_left    <= '0;
            pend_class <= '0;
            pend_cnt   <= '0;
            tmo_cnt    <= '0;
            status_q   <= '0;
        end else begin
            if (start) begin
                cur_cmd  <= desc.cmd;
                cur_addr <= desc.addr;
                cur_len  <= desc_len;
                sent_cnt <= '0;
                tmo_cnt  <= '0;
            end else if (state_q != ST_IDLE) begin
                tmo_cnt <= tmo_cnt + 1'b1;
            end
            if (state_q == ST_WDAT && lnk_wr_ready) begin
                sent_cnt <= sent_cnt + 1'b1;
            end
            if (state_q == ST_WAIT && lnk_rsp_valid) begin
                pend_class <= lnk_rsp_class;
                pend_cnt   <= rsp_cap;
                rd_left    <= rsp_cap;
            end
            if (state_q == ST_RDAT && lnk_rd_valid) begin
                rd_left <= rd_left - 1'b1;
            end
            if (finish) begin
                status_q <= fin_status;
            end else if (tmo_fire) begin
                status_q <= {RC_TIMEOUT, {CNT_W{1'b0}}};
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        status        = status_q;
        lnk_req_valid = (state_q == ST_REQ);
        lnk_cmd       = cur_cmd;
        lnk_addr      = cur_addr;
        lnk_len       = cur_len;
        lnk_wr_valid  = (state_q == ST_WDAT);
        lnk_wr_data   = tx_head;
        tx_pop        = (state_q == ST_WDAT) && lnk_wr_ready;
        rx_push       = (state_q == ST_RDAT) && lnk_rd_valid;
        rx_data       = lnk_rd_data;
    end

endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
    import aux_eng_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 4096,
    parameter int unsigned FIFO_DEPTH  = MAX_PAYLOAD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [7:0]   reg_addr,
    input  logic [7:0]   reg_wdata,
    output logic [7:0]   reg_rdata,
    output logic         lnk_req_valid,
    input  logic         lnk_req_ready,
    output logic [3:0]   lnk_cmd,
    output logic [19:0]  lnk_addr,
    output logic [4:0]   lnk_len,
    output logic         lnk_wr_valid,
    input  logic         lnk_wr_ready,
    output logic [7:0]   lnk_wr_data,
    input  logic         lnk_rsp_valid,
    input  logic [2:0]   lnk_rsp_class,
    input  logic [4:0]   lnk_rsp_count,
    input  logic         lnk_rd_valid,
    input  logic [7:0]   lnk_rd_data
);
    req_desc_t         desc;
    logic              eng_clr;
    logic              eng_send;
    logic              tx_push;
    logic [BYTE_W-1:0] tx_wdata;
    logic              tx_pop;
    logic [BYTE_W-1:0] tx_head;
    logic              tx_empty;
    logic              tx_full;
    logic              rx_push;
    logic [BYTE_W-1:0] rx_wdata;
    logic              rx_pop;
    logic [BYTE_W-1:0] rx_head;
    logic              rx_empty;
    logic              rx_full;
    logic              eng_busy;
    logic [7:0]        eng_status;

    aux_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .seq_busy   (eng_busy),
        .seq_status (eng_status),
        .rx_head    (rx_head),
        .desc       (desc),
        .clr        (eng_clr),
        .send       (eng_send),
        .tx_push    (tx_push),
        .tx_data    (tx_wdata),
        .rx_pop     (rx_pop)
    );

    aux_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (eng_clr),
        .push      (tx_push),
        .push_data (tx_wdata),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    aux_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (eng_clr),
        .push      (rx_push),
        .push_data (rx_wdata),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    aux_link_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (eng_clr),
        .send          (eng_send),
        .desc          (desc),
        .tx_head       (tx_head),
        .tx_pop        (tx_pop),
        .rx_push       (rx_push),
        .rx_data       (rx_wdata),
        .busy          (eng_busy),
        .status        (eng_status),
        .lnk_req_valid (lnk_req_valid),
        .lnk_req_ready (lnk_req_ready),
        .lnk_cmd       (lnk_cmd),
        .lnk_addr      (lnk_addr),
        .lnk_len       (lnk_len),
        .lnk_wr_valid  (lnk_wr_valid),
        .lnk_wr_ready  (lnk_wr_ready),
        .lnk_wr_data   (lnk_wr_data),
        .lnk_rsp_valid (lnk_rsp_valid),
        .lnk_rsp_class (lnk_rsp_class),
        .lnk_rsp_count (lnk_rsp_count),
        .lnk_rd_valid  (lnk_rd_valid),
        .lnk_rd_data   (lnk_rd_data)
    );

endmodule

// File: rtl/aux_req_engine_chk.sv
module aux_req_engine_chk #(
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       lnk_req_valid,
    input logic       lnk_wr_valid,
    input logic [3:0] lnk_cmd,
    input logic [4:0] lnk_len,
    input logic       eng_busy,
    input logic [7:0] eng_status
);
    localparam int unsigned RUN_W = $clog2(TIMEOUT_CYC + 2);

    logic [RUN_W-1:0] busy_run;
    logic             cfg_clear;

    assign cfg_clear = reg_wr && (reg_addr == 8'h76) && (reg_wdata == 8'hFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy_run <= '0;
        else if (!eng_busy) busy_run <= '0;
        else                busy_run <= busy_run + 1'b1;
    end

    p_req_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid |-> eng_busy);

    p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid |-> (lnk_len <= 5'd16));

    p_write_bytes_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_wr_valid |-> !lnk_cmd[0]);

    p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_status[4:0] <= 5'd16);

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> (!eng_busy && eng_status == 8'h00));

    p_tmo_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> (busy_run < RUN_W'(TIMEOUT_CYC)));

endmodule

bind aux_req_engine aux_req_engine_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .lnk_req_valid (lnk_req_valid),
    .lnk_wr_valid  (lnk_wr_valid),
    .lnk_cmd       (lnk_cmd),
    .lnk_len       (lnk_len),
    .eng_busy      (eng_busy),
    .eng_status    (eng_status)
);

// File: tb/test_aux_req_engine.sv
`timescale 1ns/1ps
module test_aux_req_engine;
    localparam int TMO = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        lnk_req_valid;
    logic        lnk_req_ready = 1'b0;
    logic [3:0]  lnk_cmd;
    logic [19:0] lnk_addr;
    logic [4:0]  lnk_len;
    logic        lnk_wr_valid;
    logic        lnk_wr_ready = 1'b0;
    logic [7:0]  lnk_wr_data;
    logic        lnk_rsp_valid = 1'b0;
    logic [2:0]  lnk_rsp_class = '0;
    logic [4:0]  lnk_rsp_count = '0;
    logic        lnk_rd_valid = 1'b0;
    logic [7:0]  lnk_rd_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] cap [32];

    always #10 clk = ~clk;

    aux_req_engine #(.TIMEOUT_CYC(TMO)) i_aux_req_engine (.*);

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not end, act=hung exp=done");
        report();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic link_accept();
        @(negedge clk);
        for (int i = 0; i < 20 && !lnk_req_valid; i++) @(negedge clk);
        lnk_req_ready = 1'b1;
        @(negedge clk);
        lnk_req_ready = 1'b0;
    endtask

    task automatic link_take(input int n);
        lnk_wr_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            chk("R4 wr_valid", lnk_wr_valid, 1);
            cap[i] = lnk_wr_data;
            @(negedge clk);
        end
        lnk_wr_ready = 1'b0;
    endtask

    task automatic link_reply(input logic [2:0] cls, input logic [4:0] cnt);
        lnk_rsp_valid = 1'b1; lnk_rsp_class = cls; lnk_rsp_count = cnt;
        @(negedge clk);
        lnk_rsp_valid = 1'b0;
    endtask

    task automatic link_give(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            lnk_rd_valid = 1'b1; lnk_rd_data = base + 8'(i);
            @(negedge clk);
        end
        lnk_rd_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 req_valid", lnk_req_valid, 0);
        host_rd(8'h7D, d); chk("R1 adr0", d, 0);
        host_rd(8'h7F, d); chk("R1 adr2", d, 0);
        host_rd(8'h80, d); chk("R1 len", d, 0);
        host_rd(8'h83, d); chk("R1 ctrl", d, 0);
        host_rd(8'h84, d); chk("R1 status", d, 0);
    endtask

    task automatic t_unlisted();
        logic [7:0] d;
        host_wr(8'h50, 8'hAA);
        host_rd(8'h50, d); chk("R11 unlisted read", d, 0);
        host_rd(8'h7D, d); chk("R11 no side effect", d, 0);
    endtask

    task automatic t_write_req();
        logic [7:0] d;
        host_wr(8'h7D, 8'h45); host_wr(8'h7E, 8'h23); host_wr(8'h7F, 8'h81);
        host_wr(8'h80, 8'h03);
        host_rd(8'h7F, d); chk("R2 adr2 readback", d, 8'h81);
        host_rd(8'h7E, d); chk("R2 adr1 readback", d, 8'h23);
        for (int i = 0; i < 4; i++) host_wr(8'h81, 8'h10 + 8'(i));
        host_wr(8'h83, 8'h01);
        host_rd(8'h83, d); chk("R5 busy during", d, 1);
        link_accept();
        chk("R2 lnk_cmd", lnk_cmd, 4'h8);
        chk("R2 lnk_addr", lnk_addr, 20'h12345);
        chk("R3 lnk_len", lnk_len, 4);
        link_take(4);
        for (int i = 0; i < 4; i++) chk("R4 byte order", cap[i], 8'h10 + 8'(i));
        host_wr(8'h83, 8'h01);      // R5: send while busy
        link_reply(3'd3, 5'd4);
        host_rd(8'h83, d); chk("R5 send cleared", d, 0);
        host_rd(8'h84, d); chk("R6 status ack", d, 8'h64);
        chk("R5 no relaunch", lnk_req_valid, 0);
    endtask

    task automatic t_read_req();
        logic [7:0] d;
        host_wr(8'h7F, 8'h91); host_wr(8'h80, 8'h02);
        host_wr(8'h83, 8'h01);
        link_accept();
        chk("R3 read len", lnk_len, 3);
        chk("R4 no wr bytes on read", lnk_wr_valid, 0);
        link_reply(3'd3, 5'd3);
        link_give(3, 8'hC0);
        host_rd(8'h84, d); chk("R6 status read", d, 8'h63);
        for (int i = 0; i < 3; i++) begin
            host_rd(8'h82, d); chk("R7 pop order", d, 8'hC0 + 8'(i));
        end
        host_rd(8'h82, d); chk("R8 empty pop", d, 0);
        host_rd(8'h82, d); chk("R8 empty pop again", d, 0);
    endtask

    task automatic t_nopay();
        logic [7:0] d;
        host_wr(8'h7F, 8'h80); host_wr(8'h80, 8'h85);
        host_wr(8'h83, 8'h01);
        link_accept();
        chk("R3 no payload len", lnk_len, 0);
        chk("R3 no payload bytes", lnk_wr_valid, 0);
        link_reply(3'd1, 5'd0);
        host_rd(8'h84, d); chk("R6 status nack", d, 8'h20);
        host_rd(8'h83, d); chk("R3 done", d, 0);
    endtask

    task automatic t_full();
        logic [7:0] d;
        host_wr(8'h76, 8'hFF);
        for (int i = 0; i < 17; i++) host_wr(8'h81, 8'hA0 + 8'(i));
        host_wr(8'h7F, 8'h00); host_wr(8'h80, 8'h0F);
        host_wr(8'h83, 8'h01);
        link_accept();
        chk("R3 max len", lnk_len, 16);
        link_take(16);
        for (int i = 0; i < 16; i++) chk("R4 full fifo order", cap[i], 8'hA0 + 8'(i));
        chk("R4 overflow dropped", lnk_wr_valid, 0);
        link_reply(3'd2, 5'd20);
        host_rd(8'h84, d); chk("R6 count saturates", d, 8'h50);
    endtask

    task automatic t_timeout();
        logic [7:0] d;
        host_wr(8'h7F, 8'h10); host_wr(8'h80, 8'h80);
        host_wr(8'h83, 8'h01);
        repeat (TMO - 2) @(negedge clk);
        chk("R9 still busy", lnk_req_valid, 1);
        @(negedge clk);
        chk("R9 last busy cycle", lnk_req_valid, 1);
        @(negedge clk);
        chk("R9 ended", lnk_req_valid, 0);
        host_rd(8'h84, d); chk("R9 status", d, 8'hE0);
        host_rd(8'h83, d); chk("R9 send cleared", d, 0);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        host_wr(8'h7D, 8'h5A);
        host_wr(8'h76, 8'h12);
        host_rd(8'h7D, d); chk("R10 other value ignored", d, 8'h5A);
        host_wr(8'h7F, 8'h91); host_wr(8'h80, 8'h01);
        host_wr(8'h83, 8'h01);
        link_accept();
        lnk_rsp_valid = 1'b1; lnk_rsp_class = 3'd3; lnk_rsp_count = 5'd2;
        reg_wr = 1'b1; reg_addr = 8'h76; reg_wdata = 8'hFF;
        @(negedge clk);
        lnk_rsp_valid = 1'b0; reg_wr = 1'b0;
        link_give(2, 8'hE0);
        chk("R10 no request", lnk_req_valid, 0);
        host_rd(8'h83, d); chk("R10 busy cleared", d, 0);
        host_rd(8'h84, d); chk("R10 status cleared", d, 0);
        host_rd(8'h82, d); chk("R10 rx fifo empty", d, 0);
        host_rd(8'h7D, d); chk("R10 regs cleared", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlisted();
        t_write_req();
        t_read_req();
        t_nopay();
        t_full();
        t_timeout();
        t_clear();
        repeat (3) @(negedge clk);
        report();
    end

endmodule